// File: doc/BRIEF.md
# DRAM Controller Control Sequencer

This block decides when a DRAM memory controller may issue queued commands. A 32-bit control word, written through a simple register port, carries three active bits: a start bit that enables command processing, a power-down request and a one-shot mode-register-write request. The block owns the clock-enable line to the memory devices. It runs the full power-down entry and exit. It also steps through the mode-register writes, both once after start-up and whenever software asks again.

Command traffic is gated in two places. The `q_accept` output tells the queue front end whether new commands may enter the core queue. It depends only on the controller and PHY initialization flags. The `cq_issue` strobe pops and issues the head command. It fires only once the block has been started and is running normally, with no power-down or mode-register work pending. Power-down entry waits for the current burst to drain, pulses a precharge-all strobe and then lowers the clock enable. Exit raises the clock enable and holds off commands for a fixed settling window. Each 0-to-1 change of the start bit emits a one-cycle DLL reset pulse, so the DLL can relock after a clock change.

Top module: `dram_ctl_seq`

## Requirements
- R1: Control word bits: bit 0 = start, bit 16 = power-down, bit 24 = mode-register-write. `reg_rdata` returns start in bit 0 and power-down in bit 16. Bit 24 and all other bits always read as 0.
- R2: Until start has been set, `cq_issue` stays 0 even when a command is queued. `q_accept` still follows the initialization flags.
- R3: `q_accept` is 1 exactly when `ctrl_init_done` and `phy_init_done` are both 1. `cq_issue` is never 1 while `q_accept` is 0.
- R4: Writing start back to 0 after the controller is running does not stop command issue.
- R5: Every register write that changes start from 0 to 1 produces `dll_rst` high for exactly one cycle, in the cycle after the write.
- R6: After start is set with `phy_init_done` high, the clock enable rises and NUM_MR mode-register writes follow automatically. They come as `mr_wr` pulses with `mr_sel` = 0,1,…,NUM_MR-1 in order, MR_GAP cycles apart.
- R7: Setting power-down waits while `burst_busy` is 1. It then pulses `pre_all` for one cycle while `cke` is still high, and `cke` is low in the following cycle.
- R8: While power-down is 1 no command is issued. The clock enable stays low until power-down is cleared.
- R9: After power-down is cleared, `cke` rises and the first command issues exactly XP_CYC cycles after the first cycle with `cke` high.
- R10: A write with bit 24 set runs a fresh NUM_MR-write mode-register sequence with the clock enable high. No command issues while it runs.
- R11: A mode-register-write request written while `cke` is low is dropped. It produces no `mr_wr`, either then or after power-down exit.
- R12: When power-down and mode-register-write arrive in the same write, all NUM_MR mode-register writes complete before the `pre_all` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word readback |
| ctrl_init_done | input | 1 | Controller initialization complete status |
| phy_init_done | input | 1 | PHY initialization complete |
| cq_valid | input | 1 | Command queue holds a command |
| q_accept | output | 1 | New commands may enter the core queue |
| cq_issue | output | 1 | Issue and pop the head command this cycle |
| burst_busy | input | 1 | A data burst is still in progress |
| cke | output | 1 | Clock enable to the DRAM devices |
| pre_all | output | 1 | Precharge-all command strobe |
| mr_wr | output | 1 | Mode-register write command strobe |
| mr_sel | output | MR_SEL_W | Index of the mode register being written |
| dll_rst | output | 1 | One-cycle DLL reset pulse |

## Verification
The assertions rely on a few input assumptions. `burst_busy` must eventually fall once power-down is requested. Power-down must not be cleared while the drain or precharge steps are still in flight. Start must not be dropped before the first mode-register sequence finishes. The directed stimulus follows these rules: every control write is issued at a falling edge and lasts a single cycle, and power-down is cleared only after `cke` has been observed low. The initialization flags are lowered only while the controller is running, and never during a mode-register or power-down sequence.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    localparam int CW_W      = 32;
    localparam int START_BIT = 0;
    localparam int PD_BIT    = 16;
    localparam int WMR_BIT   = 24;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_INIT  = 3'd1,
        S_RUN   = 3'd2,
        S_MRW   = 3'd3,
        S_DRAIN = 3'd4,
        S_PRE   = 3'd5,
        S_PD    = 3'd6,
        S_EXIT  = 3'd7
    } seq_state_e;

endpackage

// File: rtl/dram_seq_dllrst.sv
module dram_seq_dllrst (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic dll_rst_o
);
    typedef struct packed {
        logic prev;
    } dll_regs_t;

    dll_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.prev = start_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dll_rst_o = start_i && !r_q.prev;

    // the relock pulse never stretches beyond one cycle
    assert_dll_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dll_rst_o |=> !dll_rst_o);

endmodule

// File: rtl/dram_seq_mrw.sv
module dram_seq_mrw #(
    parameter int NUM_MR = 4,
    parameter int MR_GAP = 2,
    localparam int SEL_W = (NUM_MR > 1) ? $clog2(NUM_MR) : 1,
    localparam int GAP_W = (MR_GAP > 1) ? $clog2(MR_GAP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    output logic             mr_wr_o,
    output logic [SEL_W-1:0] mr_sel_o,
    output logic             done_o
);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_MR - 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(MR_GAP - 1);

    typedef struct packed {
        logic             active;
        logic [SEL_W-1:0] idx;
        logic [GAP_W-1:0] gap;
    } mrw_regs_t;

    mrw_regs_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        mr_wr_o = r_q.active && (r_q.gap == '0);
        done_o  = 1'b0;
        if (go_i) begin
            r_d.active = 1'b1;
            r_d.idx    = '0;
            r_d.gap    = '0;
        end else if (mr_wr_o) begin
            if (r_q.idx == LAST_SEL) begin
                r_d.active = 1'b0;
                done_o     = 1'b1;
            end else begin
                r_d.idx = r_q.idx + 1'b1;
                r_d.gap = GAP_LOAD;
            end
        end else if (r_q.active) begin
            r_d.gap = r_q.gap - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mr_sel_o = r_q.idx;

    // the index never runs past the last mode register
    assert_mr_index_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.active |-> (r_q.idx <= LAST_SEL));

    // the final write closes the sequence
    assert_mr_last_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_wr_o && (mr_sel_o == LAST_SEL) && !go_i) |=> !mr_wr_o);

endmodule

// File: rtl/dram_ctl_seq.sv
module dram_ctl_seq
    import dram_seq_pkg::*;
#(
    parameter int NUM_MR = 4,
    parameter int MR_GAP = 2,
    parameter int XP_CYC = 3,
    localparam int MR_SEL_W = (NUM_MR > 1) ? $clog2(NUM_MR) : 1,
    localparam int XP_W     = (XP_CYC > 1) ? $clog2(XP_CYC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                ctrl_init_done,
    input  logic                phy_init_done,
    input  logic                cq_valid,
    output logic                q_accept,
    output logic                cq_issue,
    input  logic                burst_busy,
    output logic                cke,
    output logic                pre_all,
    output logic                mr_wr,
    output logic [MR_SEL_W-1:0] mr_sel,
    output logic                dll_rst
);
    localparam logic [XP_W-1:0] XP_LOAD = XP_W'(XP_CYC - 1);

    typedef struct packed {
        seq_state_e      state;
        logic            start;
        logic            pd;
        logic            pend;
        logic            cke;
        logic [XP_W-1:0] xcnt;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic      mrw_go;
    logic      mrw_done;

    always_comb begin
        r_d    = r_q;
        mrw_go = 1'b0;
        unique case (r_q.state)
            S_IDLE: if (r_q.start && phy_init_done) begin
                r_d.state = S_INIT;
                r_d.cke   = 1'b1;
                mrw_go    = 1'b1;
            end
            S_INIT, S_MRW: if (mrw_done) r_d.state = S_RUN;
            S_RUN: begin
                if (r_q.pend) begin
                    r_d.state = S_MRW;
                    r_d.pend  = 1'b0;
                    mrw_go    = 1'b1;
                end else if (r_q.pd) begin
                    r_d.state = S_DRAIN;
                end
            end
            S_DRAIN: if (!burst_busy) r_d.state = S_PRE;
            S_PRE: begin
                r_d.state = S_PD;
                r_d.cke   = 1'b0;
            end
            S_PD: if (!r_q.pd) begin
                r_d.state = S_EXIT;
                r_d.cke   = 1'b1;
                r_d.xcnt  = XP_LOAD;
            end
            S_EXIT: begin
                if (r_q.xcnt == '0) r_d.state = S_RUN;
                else                r_d.xcnt  = r_q.xcnt - 1'b1;
            end
            default: r_d.state = S_IDLE;
        endcase
        if (reg_wr) begin
            r_d.start = reg_wdata[START_BIT];
            r_d.pd    = reg_wdata[PD_BIT];
            if (reg_wdata[WMR_BIT] && r_q.cke) r_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    dram_seq_mrw #(
        .NUM_MR (NUM_MR),
        .MR_GAP (MR_GAP)
    ) u_mrw (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (mrw_go),
        .mr_wr_o  (mr_wr),
        .mr_sel_o (mr_sel),
        .done_o   (mrw_done)
    );

    dram_seq_dllrst u_dll (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (r_q.start),
        .dll_rst_o (dll_rst)
    );

    always_comb begin
        reg_rdata            = '0;
        reg_rdata[START_BIT] = r_q.start;
        reg_rdata[PD_BIT]    = r_q.pd;
    end

    assign q_accept = ctrl_init_done && phy_init_done;
    assign cq_issue = (r_q.state == S_RUN) && !r_q.pend && !r_q.pd && cq_valid && q_accept;
    assign cke      = r_q.cke;
    assign pre_all  = (r_q.state == S_PRE);

    // clock enable only drops right after a precharge-all
    assert_pre_before_cke_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(pre_all));

    assert_cke_low_after_pre_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all |=> !cke);

    assert_no_issue_cke_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !cq_issue);

    // first cycle of a raised clock enable never carries a command
    assert_exit_holdoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> !cq_issue);

    assert_no_issue_during_mrw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mr_wr |-> !cq_issue);

    assert_mrw_needs_cke_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mr_wr |-> cke);

endmodule

// File: tb/sim_dram_ctl_seq.sv
module sim_dram_ctl_seq;
    localparam int NMR  = 4;
    localparam int GAP  = 2;
    localparam int XP   = 3;
    localparam int SELW = (NMR > 1) ? $clog2(NMR) : 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            ctrl_init_done = 1'b0;
    logic            phy_init_done = 1'b0;
    logic            cq_valid = 1'b0;
    logic            q_accept;
    logic            cq_issue;
    logic            burst_busy = 1'b0;
    logic            cke;
    logic            pre_all;
    logic            mr_wr;
    logic [SELW-1:0] mr_sel;
    logic            dll_rst;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    dram_ctl_seq #(.NUM_MR(NMR), .MR_GAP(GAP), .XP_CYC(XP)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ctrl_init_done(ctrl_init_done),
        .phy_init_done(phy_init_done), .cq_valid(cq_valid), .q_accept(q_accept),
        .cq_issue(cq_issue), .burst_busy(burst_busy), .cke(cke), .pre_all(pre_all),
        .mr_wr(mr_wr), .mr_sel(mr_sel), .dll_rst(dll_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic t_reset;
        chk("R1 reset rdata", reg_rdata, 0);
        chk("R7 reset cke", {31'b0, cke}, 0);
        chk("R2 reset issue", {31'b0, cq_issue}, 0);
        chk("R6 reset mr_wr", {31'b0, mr_wr}, 0);
        chk("R5 reset dll", {31'b0, dll_rst}, 0);
    endtask

    task automatic t_prestart;
        cq_valid = 1'b1;
        phy_init_done = 1'b0;
        ctrl_init_done = 1'b1;
        #1 chk("R3 accept off phy low", {31'b0, q_accept}, 0);
        phy_init_done = 1'b1;
        #1 chk("R3 accept on", {31'b0, q_accept}, 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R2 no issue before start", {31'b0, cq_issue}, 0);
        end
    endtask

    task automatic t_init;
        int cnt = 0;
        int last = 0;
        cq_valid = 1'b0;
        wr(32'h0000_0001);
        chk("R5 dll pulse on start", {31'b0, dll_rst}, 1);
        chk("R1 rdata start", reg_rdata, 32'h1);
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (i == 1) chk("R5 dll one cycle", {31'b0, dll_rst}, 0);
            if (mr_wr) begin
                chk("R6 mr order", {{(32-SELW){1'b0}}, mr_sel}, cnt);
                chk("R6 cke high in mrw", {31'b0, cke}, 1);
                if (cnt > 0) chk("R6 mr spacing", i - last, GAP);
                last = i;
                cnt++;
            end
        end
        chk("R6 mr count", cnt, NMR);
        cq_valid = 1'b1;
        #1 chk("R3 issue after init", {31'b0, cq_issue}, 1);
    endtask

    task automatic t_gate;
        ctrl_init_done = 1'b0;
        #1 chk("R3 accept off", {31'b0, q_accept}, 0);
        chk("R3 issue held", {31'b0, cq_issue}, 0);
        @(negedge clk);
        ctrl_init_done = 1'b1;
        #1 chk("R3 issue resumes", {31'b0, cq_issue}, 1);
    endtask

    task automatic t_stop;
        wr(32'h0);
        chk("R5 no dll on clear", {31'b0, dll_rst}, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R4 issue after start cleared", {31'b0, cq_issue}, 1);
        end
        wr(32'h1);
        chk("R5 dll on recycle", {31'b0, dll_rst}, 1);
        @(negedge clk);
        chk("R5 dll recycle one cycle", {31'b0, dll_rst}, 0);
        chk("R4 still issuing", {31'b0, cq_issue}, 1);
    endtask

    task automatic t_pd;
        bit seen = 0;
        burst_busy = 1'b1;
        wr(32'h0001_0001);
        chk("R1 rdata pd", reg_rdata, 32'h0001_0001);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R7 no pre while busy", {31'b0, pre_all}, 0);
            chk("R7 cke held while busy", {31'b0, cke}, 1);
            chk("R8 no issue in drain", {31'b0, cq_issue}, 0);
        end
        burst_busy = 1'b0;
        for (int i = 0; i < 10 && !seen; i++) begin
            @(negedge clk);
            if (pre_all) begin
                seen = 1;
                chk("R7 cke high at pre", {31'b0, cke}, 1);
                @(negedge clk);
                chk("R7 cke low after pre", {31'b0, cke}, 0);
                chk("R7 pre single", {31'b0, pre_all}, 0);
            end
        end
        chk("R7 pre seen", {31'b0, seen}, 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R8 suspended", {31'b0, cq_issue}, 0);
            chk("R8 cke low", {31'b0, cke}, 0);
        end
    endtask

    task automatic t_exit;
        int n = 0;
        bit up = 0;
        bit hit = 0;
        wr(32'h1);
        for (int i = 0; i < 10 && !up; i++) begin
            if (cke) up = 1; else @(negedge clk);
        end
        chk("R9 cke rises", {31'b0, up}, 1);
        for (int i = 0; i < 20 && !hit; i++) begin
            if (cq_issue) hit = 1;
            else begin @(negedge clk); n++; end
        end
        chk("R9 holdoff cycles", n, XP);
    endtask

    task automatic t_wmr;
        int cnt = 0;
        wr(32'h0100_0001);
        chk("R10 wmr reads zero", reg_rdata, 32'h1);
        for (int i = 0; i < 30; i++) begin
            if (mr_wr) begin
                cnt++;
                chk("R10 cke during mrw", {31'b0, cke}, 1);
            end
            if (i < 3) chk("R10 no issue in mrw", {31'b0, cq_issue}, 0);
            @(negedge clk);
        end
        chk("R10 mr count", cnt, NMR);
        chk("R10 issue after mrw", {31'b0, cq_issue}, 1);
    endtask

    task automatic t_wmr_pd;
        int cnt = 0;
        wr(32'h0001_0001);
        repeat (12) @(negedge clk);
        chk("R11 in power-down", {31'b0, cke}, 0);
        wr(32'h0101_0001);
        for (int i = 0; i < 10; i++) begin
            if (mr_wr) cnt++;
            @(negedge clk);
        end
        wr(32'h1);
        for (int i = 0; i < 30; i++) begin
            if (mr_wr) cnt++;
            @(negedge clk);
        end
        chk("R11 request dropped", cnt, 0);
        chk("R11 cke back", {31'b0, cke}, 1);
    endtask

    task automatic t_both;
        int cnt = 0;
        bit seen = 0;
        wr(32'h0101_0001);
        for (int i = 0; i < 40; i++) begin
            if (mr_wr) cnt++;
            if (pre_all && !seen) begin
                seen = 1;
                chk("R12 mrw done before pre", cnt, NMR);
            end
            @(negedge clk);
        end
        chk("R12 pre seen", {31'b0, seen}, 1);
        chk("R12 powered down", {31'b0, cke}, 0);
        wr(32'h1);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prestart();
        t_init();
        t_gate();
        t_stop();
        t_pd();
        t_exit();
        t_wmr();
        t_wmr_pd();
        t_both();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule